// File: doc/BRIEF.md
# Automatic Input Level Control

This block steers a 7-bit gain code for a programmable input amplifier. It looks at one signed audio sample per strobe. A loud sample schedules a gain decrease, which is the limiter. A long enough stretch of quiet samples schedules a gain increase, which is recovery. Recovery climbs toward a programmable ceiling code and never goes past it. A scheduled change takes effect on a later sample that is a zero crossing of the waveform. If no crossing arrives within a selectable number of samples, the change takes effect anyway.

Each gain code step is 0.5 dB. Code 0 stands for -8 dB and code 71 stands for +27.5 dB. The code leaves reset at 36H. Every time the code actually changes, the block raises a one-cycle update strobe so that the downstream gain stage can pick up the new value. The analog stage and the conversion from code to linear gain sit outside this block.

Top module: `input_level_ctrl`

## Requirements
- R1: After reset, `gain` is 36H and `gain_upd` is 0.
- R2: `gain` stays within 0 to 71, where a higher code means more gain. With `ref_code` of 71 or more, recovery stops at 71.
- R3: A strobed sample whose magnitude exceeds the selected limit schedules a decrease. The decrease is applied on a later strobed sample that is a zero crossing. A zero crossing is a sample whose sign bit differs from the sign bit of the previous strobed sample, or a sample equal to 0.
- R4: If no zero crossing follows, a scheduled change is applied on the N-th strobed sample after it was scheduled, with N = 128 << `zto_sel`.
- R5: A decrease removes 1 code when `lim_step`=0 and 2 codes when `lim_step`=1. The result floors at 0.
- R6: A sample counts as quiet when its magnitude is at most 13045. Once W = 128 << `wait_sel` consecutive quiet samples have passed since the last applied change, a further quiet sample schedules an increase. Every applied change restarts this count.
- R7: An increase adds 1 code when `rcv_step`=0 and 2 codes when `rcv_step`=1. It is neither scheduled nor applied if the new code would exceed `ref_code`; in that case the code holds.
- R8: The limit is 20675 when `thr_sel`=0 and 16423 when `thr_sel`=1.
- R9: A loud sample that arrives while an increase is pending replaces the increase with a decrease.
- R10: A strobed sample with `enable`=0 leaves `gain` unchanged and cancels any pending change, the wait count and the timeout count.
- R11: `gain` updates in the cycle after the strobed sample that applies a change. `gain_upd` is high for exactly that cycle, and only when the code actually changed.
- R12: Without `smp_valid`, the value of `smp_data` has no effect on `gain`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Level control active |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed two's-complement sample |
| thr_sel | input | 1 | Limiter level select |
| lim_step | input | 1 | Decrease size: 0 gives 1 code, 1 gives 2 codes |
| rcv_step | input | 1 | Increase size: 0 gives 1 code, 1 gives 2 codes |
| zto_sel | input | 2 | Zero-crossing timeout, 128 << value samples |
| wait_sel | input | 2 | Recovery wait, 128 << value samples |
| ref_code | input | 7 | Recovery ceiling code |
| gain | output | 7 | Current gain code |
| gain_upd | output | 1 | One-cycle pulse when the code changes |

## Verification
On every cycle, the assertions check these properties:
- The code range.
- That the code changes only on a strobe and only while enabled.
- That every change is flagged by the strobe and is at most two codes.
- That an increase never lands above the ceiling.

Some behaviour only the bench scenarios can show. This covers the exact sample on which a scheduled change lands: at a sign change, at a zero sample, or at the timeout. It also covers the length of the quiet wait, the choice between the two limits, a loud sample overriding a pending increase, and recovery stopping short of a ceiling that an increment would overshoot. For these, the bench runs a sample-by-sample model that follows the requirements.

// File: rtl/input_level_ctrl.sv
module input_level_ctrl #(
  parameter int DW        = 16,
  parameter int GW        = 7,
  parameter int GMAX      = 71,
  parameter int INIT_GAIN = 'h36,
  parameter int LIM_LVL0  = 20675,
  parameter int LIM_LVL1  = 16423,
  parameter int QUIET_LVL = 13045,
  parameter int TBASE     = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          thr_sel,
  input  logic          lim_step,
  input  logic          rcv_step,
  input  logic [1:0]    zto_sel,
  input  logic [1:0]    wait_sel,
  input  logic [GW-1:0] ref_code,
  output logic [GW-1:0] gain,
  output logic          gain_upd
);
  localparam int CW = $clog2(TBASE * 8) + 1;
  localparam logic [DW:0] L0 = (DW+1)'(LIM_LVL0);
  localparam logic [DW:0] L1 = (DW+1)'(LIM_LVL1);
  localparam logic [DW:0] LQ = (DW+1)'(QUIET_LVL);
  localparam logic [GW:0] GTOP = (GW+1)'(GMAX);

  typedef enum logic [1:0] {P_NONE, P_DN, P_UP} pend_t;

  pend_t         pend;
  logic [CW-1:0] tcnt, wcnt;
  logic          prev_neg;

  logic [DW:0] ext, mag;
  assign ext = {smp_data[DW-1], smp_data};
  assign mag = ext[DW] ? (~ext + 1'b1) : ext;

  logic over, quiet, zc;
  assign over  = mag > (thr_sel ? L1 : L0);
  assign quiet = mag <= LQ;
  assign zc    = (smp_data == '0) || (smp_data[DW-1] != prev_neg);

  logic [CW-1:0] tmo_last, wlen;
  assign tmo_last = CW'(TBASE << zto_sel) - 1'b1;
  assign wlen     = CW'(TBASE << wait_sel);

  logic [GW:0] cap, lstep, rstep, up_sum;
  logic [GW-1:0] dn_val, new_gain;
  logic up_ok, apply;
  assign cap    = ({1'b0, ref_code} > GTOP) ? GTOP : {1'b0, ref_code};
  assign lstep  = lim_step ? (GW+1)'(2) : (GW+1)'(1);
  assign rstep  = rcv_step ? (GW+1)'(2) : (GW+1)'(1);
  assign up_sum = {1'b0, gain} + rstep;
  assign up_ok  = up_sum <= cap;
  assign dn_val = ({1'b0, gain} < lstep) ? '0 : GW'({1'b0, gain} - lstep);
  assign apply  = (pend != P_NONE) && (zc || tcnt >= tmo_last);
  assign new_gain = (pend == P_DN) ? dn_val : (up_ok ? up_sum[GW-1:0] : gain);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain     <= GW'(INIT_GAIN);
      gain_upd <= 1'b0;
      pend     <= P_NONE;
      tcnt     <= '0;
      wcnt     <= '0;
      prev_neg <= 1'b0;
    end else begin
      gain_upd <= 1'b0;
      if (smp_valid) begin
        prev_neg <= smp_data[DW-1];
        if (!enable) begin
          pend <= P_NONE;
          tcnt <= '0;
          wcnt <= '0;
        end else begin
          if (apply) begin
            gain     <= new_gain;
            gain_upd <= new_gain != gain;
            tcnt     <= '0;
            pend     <= over ? P_DN : P_NONE;
          end else begin
            tcnt <= (pend == P_NONE) ? '0 : tcnt + 1'b1;
            if (over)
              pend <= P_DN;
            else if (pend == P_NONE && wcnt >= wlen && quiet && up_ok)
              pend <= P_UP;
          end
          if (!quiet || apply)
            wcnt <= '0;
          else if (wcnt < wlen)
            wcnt <= wcnt + 1'b1;
        end
      end
    end
  end
endmodule

module input_level_ctrl_chk #(
  parameter int GW   = 7,
  parameter int GMAX = 71
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          smp_valid,
  input logic [GW-1:0] ref_code,
  input logic [GW-1:0] gain,
  input logic          gain_upd
);
  a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gain) <= GMAX);
  a_r12_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(gain) && !gain_upd);
  a_r10_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !enable) |=> $stable(gain) && !gain_upd);
  a_r11_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (gain != $past(gain)) |-> gain_upd);
  a_r11_flag_means_change: assert property (@(posedge clk) disable iff (!rst_n)
    gain_upd |-> (gain != $past(gain)));
  a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    gain_upd |-> (((gain > $past(gain)) ? (gain - $past(gain)) : ($past(gain) - gain)) <= GW'(2)));
  a_r7_below_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_upd && gain > $past(gain)) |-> gain <= $past(ref_code));
endmodule

bind input_level_ctrl input_level_ctrl_chk #(.GW(GW), .GMAX(GMAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .smp_valid(smp_valid),
  .ref_code(ref_code), .gain(gain), .gain_upd(gain_upd));

// File: tb/input_level_ctrl_tb_top.sv
module input_level_ctrl_tb_top;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, smp_valid = 1'b0;
  logic signed [15:0] smp_data = '0;
  logic thr_sel = 1'b0, lim_step = 1'b0, rcv_step = 1'b0;
  logic [1:0] zto_sel = '0, wait_sel = '0;
  logic [6:0] ref_code = 7'h36;
  logic [6:0] gain;
  logic gain_upd;

  input_level_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .smp_valid(smp_valid),
    .smp_data(smp_data), .thr_sel(thr_sel), .lim_step(lim_step),
    .rcv_step(rcv_step), .zto_sel(zto_sel), .wait_sel(wait_sel),
    .ref_code(ref_code), .gain(gain), .gain_upd(gain_upd));

  always #(CLK_NS/2) clk = ~clk;

  int total = 0, bad = 0;
  int q_g[$];
  bit q_u[$];
  string q_t[$];

  int m_g = 'h36, m_pend = 0, m_t = 0, m_w = 0;
  bit m_prev = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int x, input string tag);
    int mag, tl, wl, cap, ls, rs, ng;
    bit over, quiet, zc, apply, upok, neg, upd;
    @(negedge clk);
    smp_data  = x[15:0];
    smp_valid = 1'b1;
    neg   = x < 0;
    mag   = neg ? -x : x;
    over  = mag > (thr_sel ? 16423 : 20675);
    quiet = mag <= 13045;
    zc    = (x == 0) || (neg != m_prev);
    m_prev = neg;
    upd = 1'b0;
    if (!enable) begin
      m_pend = 0; m_t = 0; m_w = 0;
    end else begin
      tl   = (128 << zto_sel) - 1;
      wl   = 128 << wait_sel;
      cap  = (ref_code > 71) ? 71 : int'(ref_code);
      ls   = lim_step ? 2 : 1;
      rs   = rcv_step ? 2 : 1;
      upok = (m_g + rs) <= cap;
      apply = (m_pend != 0) && (zc || m_t >= tl);
      if (apply) begin
        ng = (m_pend == 1) ? ((m_g < ls) ? 0 : m_g - ls) : (upok ? m_g + rs : m_g);
        upd = ng != m_g;
        m_g = ng;
        m_t = 0;
        m_pend = over ? 1 : 0;
      end else begin
        m_t = (m_pend == 0) ? 0 : m_t + 1;
        if (over) m_pend = 1;
        else if (m_pend == 0 && m_w >= wl && quiet && upok) m_pend = 2;
      end
      if (!quiet || apply) m_w = 0;
      else if (m_w < wl) m_w++;
    end
    q_g.push_back(m_g);
    q_u.push_back(upd);
    q_t.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && smp_valid) begin
      #1;
      if (q_g.size() == 0) begin
        chk(1'b0, "R3 queue", 0, 1);
      end else begin
        int eg; bit eu; string et;
        eg = q_g.pop_front();
        eu = q_u.pop_front();
        et = q_t.pop_front();
        chk(int'(gain) == eg, et, int'(gain), eg);
        chk(gain_upd == eu, "R11", int'(gain_upd), int'(eu));
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(gain == 7'h36, "R1", int'(gain), 'h36);
    chk(gain_upd == 1'b0, "R1", int'(gain_upd), 0);
    rst_n = 1'b1;
    enable = 1'b1;
    idle(2);

    send(25000, "R3"); send(-200, "R3"); idle(2);
    chk(gain == 7'd53, "R3", int'(gain), 53);

    send(25000, "R4");
    for (int i = 0; i < 130; i++) send(300, "R4");
    idle(2);
    chk(gain == 7'd52, "R4", int'(gain), 52);
    send(25000, "R4"); send(5, "R4"); send(0, "R4"); idle(2);
    chk(gain == 7'd51, "R4", int'(gain), 51);

    lim_step = 1'b1;
    send(25000, "R5"); send(-5, "R5"); idle(2);
    chk(gain == 7'd49, "R5", int'(gain), 49);

    lim_step = 1'b0;
    thr_sel = 1'b0;
    send(18000, "R8"); send(-18000, "R8"); send(100, "R8"); idle(2);
    chk(gain == 7'd49, "R8", int'(gain), 49);
    thr_sel = 1'b1;
    send(18000, "R8"); send(-100, "R8"); idle(2);
    chk(gain == 7'd48, "R8", int'(gain), 48);

    lim_step = 1'b1;
    for (int i = 0; i < 40; i++) send((i % 2) ? -30000 : 30000, "R5");
    send(100, "R5"); idle(2);
    chk(gain == 7'd0, "R5", int'(gain), 0);

    ref_code = 7'd6; rcv_step = 1'b1; wait_sel = 2'd0;
    for (int i = 0; i < 600; i++) send((i % 2) ? -100 : 100, "R6");
    idle(2);
    chk(gain == 7'd6, "R6", int'(gain), 6);
    ref_code = 7'd7;
    for (int i = 0; i < 300; i++) send((i % 2) ? -100 : 100, "R7");
    idle(2);
    chk(gain == 7'd6, "R7", int'(gain), 6);
    rcv_step = 1'b0;
    for (int i = 0; i < 300; i++) send((i % 2) ? -100 : 100, "R7");
    idle(2);
    chk(gain == 7'd7, "R7", int'(gain), 7);
    ref_code = 7'd127; rcv_step = 1'b1;
    for (int i = 0; i < 5000; i++) send((i % 2) ? -100 : 100, "R2");
    idle(2);
    chk(gain == 7'd71, "R2", int'(gain), 71);

    lim_step = 1'b0; rcv_step = 1'b0; thr_sel = 1'b0;
    send(25000, "R9"); send(-50, "R9");
    for (int i = 0; i < 130; i++) send(100, "R9");
    send(25000, "R9"); send(-50, "R9"); idle(2);
    chk(gain == 7'd69, "R9", int'(gain), 69);

    enable = 1'b0;
    for (int i = 0; i < 10; i++) send((i % 2) ? -25000 : 25000, "R10");
    idle(2);
    chk(gain == 7'd69, "R10", int'(gain), 69);

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
      smp_data = (i % 2) ? -16'sd30000 : 16'sd30000;
    end
    idle(2);
    chk(gain == 7'd69, "R12", int'(gain), 69);
    chk(gain_upd == 1'b0, "R12", int'(gain_upd), 0);

    enable = 1'b1;
    send(25000, "R10"); send(-25000, "R10"); send(100, "R10"); idle(3);
    chk(gain == 7'd67, "R10", int'(gain), 67);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule